// File: doc/BRIEF.md
# Bypassing Three-Port Register File

This block holds the integer registers of a five-stage pipelined core. The decode stage reads two source operands at once through two read ports. Each read port is combinational from its address input. The write-back stage stores one result per clock through a single synchronous write port. The destination index of that write arrives from the end of the pipeline, not from the instruction that is in decode.

When the write port and a read port name the same register in the same cycle, the read port returns the word being written, not the stored word. This gives the effect of a write in the first half of the cycle and a read in the second half. It removes the hazard between an instruction in write-back and a dependent instruction in decode. Register 0 is hard-wired to zero. The bypass path also ignores writes aimed at register 0.

Top module: `rf_bypass3p`

## Requirements
- R1: The two read ports are independent and combinational. Each read data output reflects its own address input in the same cycle, with no clock edge in between.
- R2: With `wr_en` high, the word on `wr_data` is stored into register `wr_addr` at the rising clock edge. Later reads of that register return the stored word.
- R3: When `wr_en` is high and `wr_addr` is nonzero and equal to a read address, that read port returns `wr_data` in the same cycle, before the edge that stores it.
- R4: Register 0 always reads as zero. A write to index 0 neither stores nor bypasses, so both read ports show zero for index 0 even while `wr_en` is high with `wr_addr` = 0.
- R5: Driving `rst_n` low is an asynchronous, active-low reset. It clears every register to zero, including when the reset arrives in the middle of operation.
- R6: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` carry.
- R7: At most one register is written per clock. A later write to a register replaces the earlier value, and the other registers keep their contents.
- R8: The bypass applies only to a read port whose address matches `wr_addr`. A port reading a different register in the same cycle shows that register's stored value.
- R9: By default the block has 32 registers addressed by 5-bit indices, and all words are 32 bits. Widths are parameters checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_addr_b | input | 5 | Register index for read port B |
| wr_addr | input | 5 | Destination index of the write-back result |
| wr_data | input | 32 | Write-back result word |
| wr_en | input | 1 | Write enable for the write port |
| rd_data_a | output | 32 | Operand word from read port A |
| rd_data_b | output | 32 | Operand word from read port B |

## Verification
The hardest situation to create is a cycle in which the write port and a read port name the same register while the stored copy still holds a different value. In that cycle a missing bypass and a correct bypass give different results. The stimulus first stores a known word, then in a later cycle writes a different word to the same index while one port reads it and the other port reads a neighbouring register. It samples both outputs before the edge, and then again after the edge. The same pattern is repeated with index 0 as the target, and with both ports aimed at the written register.

// File: rtl/rf_bypass3p_pkg.sv
`timescale 1ns/1ps
package rf_bypass3p_pkg;
   localparam int RF_DEF_DATA_W = 32;
   localparam int RF_DEF_ADDR_W = 5;
   localparam int RF_RD_PORTS   = 2;

   typedef enum logic [1:0] {
      RF_SRC_ZERO  = 2'd0,
      RF_SRC_FWD   = 2'd1,
      RF_SRC_ARRAY = 2'd2
   } rf_src_e;
endpackage

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q [1<<ADDR_W]
);
   localparam int NREG = 1 << ADDR_W;

   logic [NREG-1:0] sel;

   always_comb begin
      sel = '0;
      if (wr_en) sel[wr_addr] = 1'b1;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (ZERO_REG && g == 0) begin : g_tied
         assign q[g] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] word;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word <= '0;
            else if (sel[g]) word <= wr_data;
         end
         assign q[g] = word;
      end
   end
endmodule

// File: rtl/rf_rdport.sv
`timescale 1ns/1ps
module rf_rdport
   import rf_bypass3p_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter bit BYPASS_EN = 1'b1,
   parameter bit ZERO_REG  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] arr [1<<ADDR_W],
   output logic [DATA_W-1:0] data
);
   rf_src_e src;

   always_comb begin
      if (ZERO_REG && addr == '0)
         src = RF_SRC_ZERO;
      else if (BYPASS_EN && wr_en && wr_addr == addr)
         src = RF_SRC_FWD;
      else
         src = RF_SRC_ARRAY;
   end

   always_comb begin
      case (src)
         RF_SRC_ZERO: data = '0;
         RF_SRC_FWD:  data = wr_data;
         default:     data = arr[addr];
      endcase
   end
endmodule

// File: rtl/rf_bypass3p.sv
`timescale 1ns/1ps
module rf_bypass3p
   import rf_bypass3p_pkg::*;
#(
   parameter int DATA_W    = RF_DEF_DATA_W,
   parameter int ADDR_W    = RF_DEF_ADDR_W,
   parameter bit BYPASS_EN = 1'b1,
   parameter bit ZERO_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b
);
   localparam int NREG = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("rf_bypass3p: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("rf_bypass3p: ADDR_W must lie in 1..10");
   end

   logic [DATA_W-1:0] arr [NREG];
   logic [ADDR_W-1:0] addr_v [RF_RD_PORTS];
   logic [DATA_W-1:0] data_v [RF_RD_PORTS];

   assign addr_v[0] = rd_addr_a;
   assign addr_v[1] = rd_addr_b;

   rf_store #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ZERO_REG(ZERO_REG)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .q(arr)
   );

   for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_port
      rf_rdport #(
         .DATA_W(DATA_W), .ADDR_W(ADDR_W),
         .BYPASS_EN(BYPASS_EN), .ZERO_REG(ZERO_REG)
      ) u_rd (
         .addr(addr_v[p]), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .arr(arr), .data(data_v[p])
      );
   end

   assign rd_data_a = data_v[0];
   assign rd_data_b = data_v[1];
endmodule

// File: rtl/rf_bypass3p_chk.sv
`timescale 1ns/1ps
module rf_bypass3p_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] rd_data_b
);
   assert_bypass_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && wr_addr == rd_addr_a) |-> rd_data_a == wr_data);

   assert_bypass_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && wr_addr == rd_addr_b) |-> rd_data_b == wr_data);

   assert_zero_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == '0) |-> rd_data_a == '0);

   assert_zero_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_b == '0) |-> rd_data_b == '0);

   assert_store_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0) |=>
         (rd_addr_a != $past(wr_addr)) || (wr_en && wr_addr == rd_addr_a) ||
         (rd_data_a == $past(wr_data)));

   assert_store_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0) |=>
         (rd_addr_b != $past(wr_addr)) || (wr_en && wr_addr == rd_addr_b) ||
         (rd_data_b == $past(wr_data)));
endmodule

bind rf_bypass3p rf_bypass3p_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
   .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
   .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/rf_bypass3p_bench.sv
`timescale 1ns/1ps
module rf_bypass3p_bench;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam int NR = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] rd_data_a, rd_data_b;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   bit finished = 0;

   logic [DW-1:0] shadow [NR];
   logic [DW-1:0] q_a [$];
   logic [DW-1:0] q_b [$];
   string         q_req [$];
   event          go;

   always #4 clk = ~clk;

   rf_bypass3p u_rf_bypass3p (
      .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
   );

   function automatic logic [DW-1:0] predict(input logic [AW-1:0] ra,
         input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic we);
      if (ra == '0) return '0;
      if (we && rst_n && wa == ra) return wd;
      return shadow[ra];
   endfunction

   task automatic apply(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
         input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic we,
         input string req);
      @(negedge clk);
      rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd; wr_en = we;
      q_a.push_back(predict(ra, wa, wd, we));
      q_b.push_back(predict(rb, wa, wd, we));
      q_req.push_back(req);
      -> go;
      @(posedge clk);
      if (rst_n && we && wa != '0) shadow[wa] = wd;
   endtask

   initial begin : monitor
      forever begin
         @(go);
         #1;
         begin
            logic [DW-1:0] ea, eb;
            string r;
            ea = q_a.pop_front(); eb = q_b.pop_front(); r = q_req.pop_front();
            compared++;
            if (rd_data_a !== ea) begin
               mismatched++;
               $display("FAIL %s port A: actual %h expected %h", r, rd_data_a, ea);
            end
            compared++;
            if (rd_data_b !== eb) begin
               mismatched++;
               $display("FAIL %s port B: actual %h expected %h", r, rd_data_b, eb);
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         finish_run();
      end
   end

   initial begin : driver
      for (int i = 0; i < NR; i++) shadow[i] = '0;
      // R5: registers read zero while reset is held
      apply(5'd1, 5'd31, 5'd0, '0, 1'b0, "R5");
      apply(5'd7, 5'd16, 5'd0, '0, 1'b0, "R5");
      @(negedge clk); rst_n = 1'b1;
      // R2: store then read back on a later cycle
      apply(5'd0, 5'd0, 5'd5, 32'hDEAD_BEEF, 1'b1, "R2");
      apply(5'd5, 5'd6, 5'd0, '0, 1'b0, "R2");
      apply(5'd6, 5'd0, 5'd6, 32'h1234_5678, 1'b1, "R3");
      apply(5'd6, 5'd5, 5'd0, '0, 1'b0, "R2");
      // R3 and R8: same-cycle bypass, other port keeps stored value
      apply(5'd5, 5'd6, 5'd5, 32'hA5A5_0001, 1'b1, "R3/R8");
      apply(5'd6, 5'd5, 5'd5, 32'h0BAD_F00D, 1'b1, "R3/R8");
      apply(5'd9, 5'd9, 5'd9, 32'hCAFE_0009, 1'b1, "R3");
      apply(5'd9, 5'd5, 5'd0, '0, 1'b0, "R7");
      // R4: register zero ignores writes and bypass
      apply(5'd0, 5'd0, 5'd0, 32'hFFFF_FFFF, 1'b1, "R4");
      apply(5'd0, 5'd5, 5'd0, 32'h1111_1111, 1'b1, "R4");
      // R6: disabled write changes nothing and does not bypass
      apply(5'd5, 5'd9, 5'd5, 32'h7777_7777, 1'b0, "R6");
      apply(5'd5, 5'd9, 5'd9, 32'h8888_8888, 1'b0, "R6");
      // R7: last write wins, neighbours untouched
      apply(5'd3, 5'd4, 5'd3, 32'h0000_0003, 1'b1, "R7");
      apply(5'd3, 5'd4, 5'd3, 32'h0000_0033, 1'b1, "R7");
      apply(5'd3, 5'd4, 5'd4, 32'h0000_0044, 1'b1, "R7");
      apply(5'd3, 5'd4, 5'd0, '0, 1'b0, "R7");
      // R1/R9: fill every index, then read all pairs with address changes each cycle
      for (int i = 0; i < NR; i++)
         apply(5'(NR-1-i), 5'(i), 5'(i), 32'h5A00_0000 ^ (32'(i) * 32'h0101_0107), 1'b1, "R9");
      for (int i = 0; i < NR; i++)
         apply(5'(i), 5'(NR-1-i), 5'd0, '0, 1'b0, "R1");
      // R5: reset mid-run clears all
      @(negedge clk); rst_n = 1'b0;
      for (int i = 0; i < NR; i++) shadow[i] = '0;
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < NR; i += 2)
         apply(5'(i), 5'(i+1), 5'd0, '0, 1'b0, "R5");
      apply(5'd31, 5'd30, 5'd31, 32'h3131_3131, 1'b1, "R3");
      apply(5'd31, 5'd30, 5'd0, '0, 1'b0, "R2");
      @(negedge clk);
      #2;
      finish_run();
   end
endmodule